// File: doc/BRIEF.md
# Configuration Space Index/Data Access Port

The block sits on a host I/O bus and lets software reach device configuration space through two 32-bit ports. The first is an address (index) register. It holds an enable flag and the bus, device, function and dword register numbers of the target. The second is a data window. When the enable flag is set, a read or write of the window becomes one configuration request on a downstream valid/ready interface. That request carries the latched target fields, the byte enables of the host access and the write data. The response data then completes the host read.

The host side is a simple slave. The host presents a dword address, byte enables, a read or write strobe and write data, and holds them until the block pulses `io_ready` for one cycle. When the window is disabled, or when the downstream side never answers, no stale data comes back: host reads return all-ones. A timeout bounds every forwarded access, so a missing target cannot stall the host.

The address register keeps only the bits it defines. The unused bits above the bus field and the two lowest bits read as zero. Only a write with all four byte enables set changes the register, so a narrow write to any byte of the address port has no effect. A probe that uses byte writes therefore cannot corrupt the latched value.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the address register reads 0x00000000, `req_valid` is low and `io_ready` is low.
- R2: A write to dword address 0x33E (I/O 0xCF8) with byte enables 4'b1111 loads the address register. It keeps bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register index). Bits 30:24 and 1:0 read back as zero, so writing 0xFFFFFFFF reads back 0x80FFFFFC.
- R3: A write to the address port with any byte enable pattern other than 4'b1111 leaves the register unchanged. For example, 0xF0000000 followed by a zero written with enables 4'b1000 still reads back 0x80000000.
- R4: A read of dword address 0x33F (I/O 0xCFC) with the enable bit set issues exactly one downstream request. The request has `req_write` = 0, the latched bus, device, function and register fields, and the host byte enables unchanged. The response data is returned on `io_rdata`.
- R5: A write to the data window with the enable bit set issues exactly one downstream request. The request has `req_write` = 1, the host write data and the host byte enables unchanged.
- R6: While the enable bit is clear, data window accesses issue no downstream request. Reads return 0xFFFFFFFF and writes are dropped.
- R7: A forwarded access that gets no accept, or no response, within TIMEOUT_CYCLES cycles (default 64) completes anyway, and a read then returns 0xFFFFFFFF. The next access works normally.
- R8: Writing 0x00000000 to the address port clears the enable bit, and later data window accesses generate no request.
- R9: Accesses to any other dword address complete without a downstream request, return 0xFFFFFFFF on reads, and leave the address register unchanged.
- R10: Each host access gets exactly one single-cycle `io_ready` pulse. `req_valid` and the request fields hold steady until `req_ready`, and drop right after the handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_dwaddr | input | 14 | Host I/O dword address (byte address bits 15:2) |
| io_be | input | 4 | Host byte enables |
| io_rd | input | 1 | Host read strobe, held until `io_ready` |
| io_wr | input | 1 | Host write strobe, held until `io_ready` |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data, valid with `io_ready` |
| io_ready | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Downstream configuration request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_write | output | 1 | 1 = configuration write, 0 = read |
| req_bus | output | 8 | Target bus number |
| req_dev | output | 5 | Target device number |
| req_func | output | 3 | Target function number |
| req_reg | output | 6 | Target dword register index |
| req_be | output | 4 | Byte enables passed from the host |
| req_wdata | output | 32 | Write data passed from the host |
| rsp_valid | input | 1 | Downstream response valid (one cycle) |
| rsp_rdata | input | 32 | Downstream response data |

## Verification
The assertions assume a well-behaved host and target. The host never raises read and write together, and it keeps its strobe and address steady until the completion pulse, then drops them in the next cycle. The target pulses `rsp_valid` only after it has accepted a request. The bench drives every host access through a single task that keeps these rules, and a scripted downstream model that answers only the request it has accepted. That model can withhold accept or response to exercise the timeout paths.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   localparam int CFG_DW = 32;

   // which host port an access decodes to
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_DATA = 2'd2
   } io_sel_e;

   // access sequencer states
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2,
      ST_DONE = 2'd3
   } acc_state_e;

   localparam logic [CFG_DW-1:0] NO_TARGET_DATA = '1;

endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
   import cfg_port_pkg::*;
#(
   parameter int IO_AW     = 16,
   parameter int ADDR_PORT = 'h0CF8,
   parameter int DATA_PORT = 'h0CFC
) (
   input  logic [IO_AW-3:0] io_dwaddr,
   output io_sel_e          sel
);

   localparam logic [IO_AW-3:0] ADDR_DW = (IO_AW-2)'(ADDR_PORT / 4);
   localparam logic [IO_AW-3:0] DATA_DW = (IO_AW-2)'(DATA_PORT / 4);

   if ((ADDR_PORT % 4) != 0 || (DATA_PORT % 4) != 0) begin : g_bad_align
      $error("cfg_io_decode: ports must be dword aligned");
   end
   if (ADDR_PORT == DATA_PORT) begin : g_bad_overlap
      $error("cfg_io_decode: address and data ports must differ");
   end
   if (IO_AW < 4) begin : g_bad_width
      $error("cfg_io_decode: IO_AW too small");
   end

   always_comb begin
      if (io_dwaddr == ADDR_DW)      sel = SEL_ADDR;
      else if (io_dwaddr == DATA_DW) sel = SEL_DATA;
      else                           sel = SEL_NONE;
   end

endmodule

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
   import cfg_port_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FUNC_W = 3,
   parameter int REG_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [CFG_DW-1:0] wdata,
   output logic              en,
   output logic [BUS_W-1:0]  bus,
   output logic [DEV_W-1:0]  dev,
   output logic [FUNC_W-1:0] func,
   output logic [REG_W-1:0]  regn,
   output logic [CFG_DW-1:0] rdback
);

   localparam int REG_LSB  = 2;
   localparam int FUNC_LSB = REG_LSB + REG_W;
   localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
   localparam int BUS_LSB  = DEV_LSB + DEV_W;
   localparam int BUS_TOP  = BUS_LSB + BUS_W;
   localparam int EN_BIT   = CFG_DW - 1;
   localparam logic [CFG_DW-1:0] KEEP_MASK =
      (CFG_DW'(1) << EN_BIT) | (((CFG_DW'(1) << BUS_TOP) - CFG_DW'(1)) & ~CFG_DW'(3));

   if (BUS_TOP > EN_BIT) begin : g_bad_fields
      $error("cfg_addr_latch: field widths overrun the enable bit");
   end

   logic [CFG_DW-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  addr_q <= '0;
      else if (ld) addr_q <= wdata & KEEP_MASK;
   end

   assign en     = addr_q[EN_BIT];
   assign bus    = addr_q[BUS_LSB  +: BUS_W];
   assign dev    = addr_q[DEV_LSB  +: DEV_W];
   assign func   = addr_q[FUNC_LSB +: FUNC_W];
   assign regn   = addr_q[REG_LSB  +: REG_W];
   assign rdback = addr_q;

   AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(rdback)); // R3
   AST_LOAD_TAKES_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (en == $past(wdata[EN_BIT]))); // R2

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
   import cfg_port_pkg::*;
#(
   parameter int BUS_W          = 8,
   parameter int DEV_W          = 5,
   parameter int FUNC_W         = 3,
   parameter int REG_W          = 6,
   parameter int TIMEOUT_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   // host side
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [3:0]        io_be,
   input  logic [CFG_DW-1:0] io_wdata,
   input  io_sel_e           sel,
   output logic [CFG_DW-1:0] io_rdata,
   output logic              io_ready,
   // address register
   input  logic              cfg_en,
   input  logic [BUS_W-1:0]  cfg_bus,
   input  logic [DEV_W-1:0]  cfg_dev,
   input  logic [FUNC_W-1:0] cfg_func,
   input  logic [REG_W-1:0]  cfg_regn,
   input  logic [CFG_DW-1:0] addr_rdback,
   output logic              addr_ld,
   // downstream side
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [BUS_W-1:0]  req_bus,
   output logic [DEV_W-1:0]  req_dev,
   output logic [FUNC_W-1:0] req_func,
   output logic [REG_W-1:0]  req_reg,
   output logic [3:0]        req_be,
   output logic [CFG_DW-1:0] req_wdata,
   input  logic              rsp_valid,
   input  logic [CFG_DW-1:0] rsp_rdata
);

   localparam int TMO_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES + 1) : 1;

   if (TIMEOUT_CYCLES < 0) begin : g_bad_tmo
      $error("cfg_access_ctrl: TIMEOUT_CYCLES must not be negative");
   end

   acc_state_e        state_q;
   logic [CFG_DW-1:0] rdata_q;
   logic              accept;
   logic              forward;
   logic              tmo_hit;

   assign accept  = (state_q == ST_IDLE) && (io_rd || io_wr);
   assign forward = accept && (sel == SEL_DATA) && cfg_en;
   assign addr_ld = accept && io_wr && (sel == SEL_ADDR) && (io_be == 4'hF);

   // timeout variant: a zero count waits forever
   if (TIMEOUT_CYCLES > 0) begin : g_timer
      logic [TMO_W-1:0] tmr_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                   tmr_q <= '0;
         else if (state_q == ST_IDLE)                  tmr_q <= '0;
         else if (tmr_q < TMO_W'(TIMEOUT_CYCLES))      tmr_q <= tmr_q + 1'b1;
      end
      assign tmo_hit = (tmr_q >= TMO_W'(TIMEOUT_CYCLES - 1));
   end else begin : g_no_timer
      assign tmo_hit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rdata_q   <= '0;
         req_write <= 1'b0;
         req_bus   <= '0;
         req_dev   <= '0;
         req_func  <= '0;
         req_reg   <= '0;
         req_be    <= '0;
         req_wdata <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (forward) begin
                  state_q   <= ST_REQ;
                  req_write <= io_wr;
                  req_bus   <= cfg_bus;
                  req_dev   <= cfg_dev;
                  req_func  <= cfg_func;
                  req_reg   <= cfg_regn;
                  req_be    <= io_be;
                  req_wdata <= io_wdata;
               end else if (accept) begin
                  state_q <= ST_DONE;
                  rdata_q <= ((sel == SEL_ADDR) && !io_wr) ? addr_rdback : NO_TARGET_DATA;
               end
            end
            ST_REQ: begin
               if (req_ready) begin
                  state_q <= ST_RSP;
               end else if (tmo_hit) begin
                  state_q <= ST_DONE;
                  rdata_q <= NO_TARGET_DATA;
               end
            end
            ST_RSP: begin
               if (rsp_valid) begin
                  state_q <= ST_DONE;
                  rdata_q <= rsp_rdata;
               end else if (tmo_hit) begin
                  state_q <= ST_DONE;
                  rdata_q <= NO_TARGET_DATA;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == ST_REQ);
   assign io_ready  = (state_q == ST_DONE);
   assign io_rdata  = rdata_q;

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      io_ready |=> !io_ready); // R10
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !tmo_hit) |=>
         (req_valid && $stable(req_wdata) && $stable(req_be) && $stable(req_write))); // R10
   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_valid); // R10
   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(cfg_en)); // R6

   if (TIMEOUT_CYCLES > 0) begin : g_bound
      logic [TMO_W+1:0] busy_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)                                       busy_cnt <= '0;
         else if (state_q == ST_REQ || state_q == ST_RSP)  busy_cnt <= busy_cnt + 1'b1;
         else                                              busy_cnt <= '0;
      end
      // one extra cycle covers an accept on the last waiting cycle
      AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         busy_cnt <= (TMO_W+2)'(TIMEOUT_CYCLES + 1)); // R7
   end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int IO_AW          = 16,
   parameter int ADDR_PORT      = 'h0CF8,
   parameter int DATA_PORT      = 'h0CFC,
   parameter int BUS_W          = 8,
   parameter int DEV_W          = 5,
   parameter int FUNC_W         = 3,
   parameter int REG_W          = 6,
   parameter int TIMEOUT_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IO_AW-3:0]  io_dwaddr,
   input  logic [3:0]        io_be,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [31:0]       io_wdata,
   output logic [31:0]       io_rdata,
   output logic              io_ready,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [BUS_W-1:0]  req_bus,
   output logic [DEV_W-1:0]  req_dev,
   output logic [FUNC_W-1:0] req_func,
   output logic [REG_W-1:0]  req_reg,
   output logic [3:0]        req_be,
   output logic [31:0]       req_wdata,
   input  logic              rsp_valid,
   input  logic [31:0]       rsp_rdata
);

   io_sel_e           sel;
   logic              addr_ld;
   logic              cfg_en;
   logic [BUS_W-1:0]  cfg_bus;
   logic [DEV_W-1:0]  cfg_dev;
   logic [FUNC_W-1:0] cfg_func;
   logic [REG_W-1:0]  cfg_regn;
   logic [31:0]       addr_rdback;

   cfg_io_decode #(
      .IO_AW     (IO_AW),
      .ADDR_PORT (ADDR_PORT),
      .DATA_PORT (DATA_PORT)
   ) u_decode (
      .io_dwaddr (io_dwaddr),
      .sel       (sel)
   );

   cfg_addr_latch #(
      .BUS_W  (BUS_W),
      .DEV_W  (DEV_W),
      .FUNC_W (FUNC_W),
      .REG_W  (REG_W)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (addr_ld),
      .wdata  (io_wdata),
      .en     (cfg_en),
      .bus    (cfg_bus),
      .dev    (cfg_dev),
      .func   (cfg_func),
      .regn   (cfg_regn),
      .rdback (addr_rdback)
   );

   cfg_access_ctrl #(
      .BUS_W          (BUS_W),
      .DEV_W          (DEV_W),
      .FUNC_W         (FUNC_W),
      .REG_W          (REG_W),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .io_rd       (io_rd),
      .io_wr       (io_wr),
      .io_be       (io_be),
      .io_wdata    (io_wdata),
      .sel         (sel),
      .io_rdata    (io_rdata),
      .io_ready    (io_ready),
      .cfg_en      (cfg_en),
      .cfg_bus     (cfg_bus),
      .cfg_dev     (cfg_dev),
      .cfg_func    (cfg_func),
      .cfg_regn    (cfg_regn),
      .addr_rdback (addr_rdback),
      .addr_ld     (addr_ld),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_bus     (req_bus),
      .req_dev     (req_dev),
      .req_func    (req_func),
      .req_reg     (req_reg),
      .req_be      (req_be),
      .req_wdata   (req_wdata),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata)
   );

   // a completed read of the address port never shows reserved bits
   logic rd_addr_q;
   always_ff @(posedge clk) begin
      if (!rst_n) rd_addr_q <= 1'b0;
      else        rd_addr_q <= io_rd && (sel == SEL_ADDR);
   end
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (io_ready && rd_addr_q) |-> (io_rdata[30:24] == 7'd0 && io_rdata[1:0] == 2'd0)); // R2

endmodule

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;

   localparam int TMO = 64;
   localparam logic [13:0] A_ADDR = 14'h0CF8 >> 2;
   localparam logic [13:0] A_DATA = 14'h0CFC >> 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] io_dwaddr = '0;
   logic [3:0]  io_be = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [31:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        io_ready;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic        req_write;
   logic [7:0]  req_bus;
   logic [4:0]  req_dev;
   logic [2:0]  req_func;
   logic [5:0]  req_reg;
   logic [3:0]  req_be;
   logic [31:0] req_wdata;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_rdata = '0;

   cfg_index_port #(.TIMEOUT_CYCLES(TMO)) dut (.*);

   always #5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int hs_total = 0;

   // downstream model settings
   bit          dn_accept  = 1'b1;
   bit          dn_respond = 1'b1;
   int          dn_delay   = 0;
   logic [31:0] dn_data    = '0;
   // fields seen on the last accepted request
   logic        cap_write;
   logic [7:0]  cap_bus;
   logic [4:0]  cap_dev;
   logic [2:0]  cap_func;
   logic [5:0]  cap_reg;
   logic [3:0]  cap_be;
   logic [31:0] cap_wdata;

   always @(posedge clk) if (req_valid && req_ready) hs_total++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic io_access(input bit wr, input logic [13:0] a, input logic [3:0] be,
                            input logic [31:0] wd, output logic [31:0] rd,
                            output int nreq, output int cyc);
      int  wcnt = 0;
      bit  pend = 1'b0;
      bit  done = 1'b0;
      nreq = 0;
      cyc  = 0;
      rd   = '0;
      @(negedge clk);
      io_dwaddr = a; io_be = be; io_wdata = wd; io_wr = wr; io_rd = !wr;
      req_ready = 1'b0;
      while (!done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
         rsp_valid = 1'b0;
         if (io_ready) begin
            rd = io_rdata; done = 1'b1;
            io_rd = 1'b0; io_wr = 1'b0; req_ready = 1'b0;
         end else if (req_valid) begin
            if (dn_accept && !req_ready && wcnt >= dn_delay) begin
               req_ready = 1'b1;
               cap_write = req_write; cap_bus = req_bus; cap_dev = req_dev;
               cap_func = req_func; cap_reg = req_reg; cap_be = req_be;
               cap_wdata = req_wdata;
               nreq++;
               pend = 1'b1;
            end else begin
               wcnt++;
            end
         end else begin
            req_ready = 1'b0;
            if (pend && dn_respond) begin
               rsp_valid = 1'b1; rsp_rdata = dn_data; pend = 1'b0;
            end
         end
      end
      check("R10 access completes", 32'(done), 32'd1);
      @(negedge clk);
      check("R10 ready is one cycle", 32'(io_ready), 32'd0);
   endtask

   task automatic wr_addr(input logic [31:0] v, input logic [3:0] be);
      logic [31:0] rd; int n; int c;
      io_access(1'b1, A_ADDR, be, v, rd, n, c);
   endtask

   task automatic rd_addr(output logic [31:0] v);
      int n; int c;
      io_access(1'b0, A_ADDR, 4'hF, '0, v, n, c);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R1 ready low after reset", 32'(io_ready), 32'd0);
      check("R1 req_valid low after reset", 32'(req_valid), 32'd0);
      rd_addr(v);
      check("R1 address register after reset", v, 32'h0);
   endtask

   task automatic t_full_write;
      logic [31:0] v;
      wr_addr(32'hFFFF_FFFF, 4'hF);
      rd_addr(v);
      check("R2 all-ones readback", v, 32'h80FF_FFFC);
      wr_addr(32'h8001_2A4C, 4'hF);
      rd_addr(v);
      check("R2 field readback", v, 32'h8001_2A4C);
   endtask

   task automatic t_partial;
      logic [31:0] v;
      int h0;
      h0 = hs_total;
      wr_addr(32'hF000_0000, 4'hF);
      wr_addr(32'h0000_0000, 4'b1000);
      rd_addr(v);
      check("R3 top byte write ignored", v, 32'h8000_0000);
      wr_addr(32'hFFFF_FFFF, 4'b0001);
      wr_addr(32'h0000_0000, 4'b0111);
      rd_addr(v);
      check("R3 low bytes write ignored", v, 32'h8000_0000);
      check("R3 no request from address port", 32'(hs_total - h0), 32'd0);
   endtask

   task automatic t_win_read;
      logic [31:0] v; int n; int c;
      wr_addr(32'h8001_2A4C, 4'hF);
      dn_data = 32'hDEAD_BEEF; dn_delay = 3;
      io_access(1'b0, A_DATA, 4'hF, '0, v, n, c);
      check("R4 read data returned", v, 32'hDEAD_BEEF);
      check("R4 one request", 32'(n), 32'd1);
      check("R4 read kind", 32'(cap_write), 32'd0);
      check("R4 bus", 32'(cap_bus), 32'h01);
      check("R4 device", 32'(cap_dev), 32'd5);
      check("R4 function", 32'(cap_func), 32'd2);
      check("R4 register", 32'(cap_reg), 32'h13);
      check("R4 byte enables", 32'(cap_be), 32'hF);
      dn_data = 32'h0BAD_F00D; dn_delay = 0;
      io_access(1'b0, A_DATA, 4'b0110, '0, v, n, c);
      check("R4 partial enables passed", 32'(cap_be), 32'h6);
      check("R4 second read data", v, 32'h0BAD_F00D);
   endtask

   task automatic t_win_write;
      logic [31:0] v; int n; int c;
      wr_addr(32'h80FF_F8FC, 4'hF);
      io_access(1'b1, A_DATA, 4'b0011, 32'h1234_5678, v, n, c);
      check("R5 one request", 32'(n), 32'd1);
      check("R5 write kind", 32'(cap_write), 32'd1);
      check("R5 write data", cap_wdata, 32'h1234_5678);
      check("R5 byte enables", 32'(cap_be), 32'h3);
      check("R5 bus", 32'(cap_bus), 32'hFF);
      check("R5 device", 32'(cap_dev), 32'd31);
      check("R5 function", 32'(cap_func), 32'd0);
      check("R5 register", 32'(cap_reg), 32'h3F);
   endtask

   task automatic t_disabled;
      logic [31:0] v; int n; int c; int h0;
      wr_addr(32'h0001_2A4C, 4'hF);
      h0 = hs_total;
      io_access(1'b0, A_DATA, 4'hF, '0, v, n, c);
      check("R6 disabled read all-ones", v, 32'hFFFF_FFFF);
      io_access(1'b1, A_DATA, 4'hF, 32'hAAAA_5555, v, n, c);
      check("R6 no request while disabled", 32'(hs_total - h0), 32'd0);
      check("R6 no valid while disabled", 32'(req_valid), 32'd0);
   endtask

   task automatic t_clear;
      logic [31:0] v; int n; int c; int h0;
      wr_addr(32'h8000_0800, 4'hF);
      dn_data = 32'h5A5A_0001;
      io_access(1'b0, A_DATA, 4'hF, '0, v, n, c);
      check("R8 enabled access before clear", v, 32'h5A5A_0001);
      wr_addr(32'h0000_0000, 4'hF);
      rd_addr(v);
      check("R8 register cleared", v, 32'h0);
      h0 = hs_total;
      io_access(1'b0, A_DATA, 4'hF, '0, v, n, c);
      check("R8 read after clear all-ones", v, 32'hFFFF_FFFF);
      io_access(1'b1, A_DATA, 4'hF, 32'h1, v, n, c);
      check("R8 no request after clear", 32'(hs_total - h0), 32'd0);
   endtask

   task automatic t_timeout;
      logic [31:0] v; int n; int c;
      wr_addr(32'h8003_1000, 4'hF);
      dn_respond = 1'b0;
      io_access(1'b0, A_DATA, 4'hF, '0, v, n, c);
      check("R7 no response gives all-ones", v, 32'hFFFF_FFFF);
      check("R7 request was issued", 32'(n), 32'd1);
      check("R7 bounded wait", 32'(c >= TMO && c <= TMO + 4), 32'd1);
      dn_respond = 1'b1; dn_accept = 1'b0;
      io_access(1'b0, A_DATA, 4'hF, '0, v, n, c);
      check("R7 no accept gives all-ones", v, 32'hFFFF_FFFF);
      check("R7 no accept no handshake", 32'(n), 32'd0);
      dn_accept = 1'b1; dn_data = 32'hC0DE_0007;
      io_access(1'b0, A_DATA, 4'hF, '0, v, n, c);
      check("R7 recovers after timeout", v, 32'hC0DE_0007);
   endtask

   task automatic t_undecoded;
      logic [31:0] v; int n; int c; int h0;
      wr_addr(32'h8000_0104, 4'hF);
      h0 = hs_total;
      io_access(1'b0, 14'h0CF0 >> 2, 4'hF, '0, v, n, c);
      check("R9 other port read all-ones", v, 32'hFFFF_FFFF);
      io_access(1'b1, 14'h0CF4 >> 2, 4'hF, 32'h0, v, n, c);
      check("R9 other port no request", 32'(hs_total - h0), 32'd0);
      rd_addr(v);
      check("R9 register untouched", v, 32'h8000_0104);
   endtask

   initial begin
      #1_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_write();
      t_partial();
      t_win_read();
      t_win_write();
      t_disabled();
      t_clear();
      t_timeout();
      t_undecoded();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule